// File: doc/BRIEF.md
# Bit-Permuting Register Move Unit

A combinational execution unit that moves a 64-bit value between the integer (GPR) and floating-point (FPR) register files. On the way it scatters the bits through a generalized bit reverse (GREV) steered by a 6-bit immediate. Setting that immediate to zero gives a plain bit copy. Other values give any mix of bit, nibble, byte, halfword or word swaps, so big-endian reinterpretation between integer vectors and floats needs no trip through memory.

Single-precision variants bracket the permutation with format conversion. A variant that reads an FPR first narrows its double to a single held in the low word, with the high word cleared. A variant that writes an FPR widens the low word of the permuted value back to a double. The immediate is a full 6 bits in every variant, so a single can be steered into or out of the high word. When the record flag is set, the unit also produces a 4-bit condition field and its index, chosen by which file is the destination.

Top module: `bitperm_move_unit`

## Requirements
- R1: `op_i` encodes the variant: 0 FPR→FPR, 1 FPR→FPR narrow then widen, 2 FPR→FPR narrow only, 3 FPR→FPR widen only, 4 GPR→FPR, 5 GPR→FPR widen, 6 FPR→GPR, 7 FPR→GPR narrow. `dst_gpr_o` is 1 exactly for codes 6 and 7.
- R2: For codes 0, 4 and 6, result bit i (LSB = bit 0) equals operand bit (i XOR `sh_i`). Stage k of the network swaps adjacent 2^k-bit groups when `sh_i[k]` is 1.
- R3: For codes 0, 4 and 6 with `sh_i` = 0, the result is the operand unchanged.
- R4: Codes 1, 2 and 7 narrow the operand double into bits [31:0] before the permutation and clear bits [63:32]. A normal double in single range keeps its sign, rebiases its exponent and keeps the top 23 fraction bits (truncation).
- R5: When narrowing, an infinity stays an infinity. A NaN becomes a quiet single NaN: fraction bit 22 is set and the next 22 double fraction bits are kept. An exponent above single range gives a signed infinity. Zero or a double denormal gives signed zero. A value below the single normal range becomes a truncated single denormal.
- R6: Codes 1, 3 and 5 widen bits [31:0] of the permuted value from single to double (exponent +896, fraction padded with 29 zeros). Bits [63:32] of the permuted value are ignored.
- R7: When widening, single denormals are normalized to an exact double, signed zero stays signed zero, and infinities and NaNs keep their class and fraction.
- R8: With `rec_i`=1 and an FPR destination, `cr_we_o`=1, `cr_idx_o`=1 and `cr_val_o` = `fpscr_i`, whose bits are {FX, FEX, VX, OX} from bit 3 down to bit 0.
- R9: With `rec_i`=1 and a GPR destination, `cr_we_o`=1, `cr_idx_o`=0 and `cr_val_o` = {LT, GT, EQ, SO} from bit 3 down to bit 0. LT, GT and EQ come from a signed comparison of the result with zero; SO comes from `xer_so_i`.
- R10: With `rec_i`=0, `cr_we_o`, `cr_idx_o` and `cr_val_o` are all 0, and `fpscr_i` and `xer_so_i` have no effect.
- R11: Narrowing and widening in the same operation (code 1) go through the full 64-bit network. For example, `sh_i`[5]=1 moves the narrowed single into the high word, and widening the then-empty low word gives +0.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Variant code (see R1) |
| operand_i | input | 64 | Source register value |
| sh_i | input | 6 | Permutation immediate |
| rec_i | input | 1 | Record flag: update a condition field |
| xer_so_i | input | 1 | Integer summary-overflow bit |
| fpscr_i | input | 4 | Floating-point summary bits {FX,FEX,VX,OX} |
| result_o | output | 64 | Value for the destination register |
| dst_gpr_o | output | 1 | 1 when the destination is a GPR |
| cr_we_o | output | 1 | Condition field write enable |
| cr_idx_o | output | 3 | Condition field index |
| cr_val_o | output | 4 | Condition field value |

## Verification
Narrowing, permutation and widening can all act on one operand in the same operation. The sharpest cases put a nonzero `sh_i`[5] together with a single form. Code 7 with `sh_i`=32 must leave the single in the high word. Code 1 with `sh_i`=32 must widen a zero low word to +0.0. A GPR-destination record must then derive its sign and zero flags from that permuted, not the raw, value. These cases are driven as directed vectors and then mixed into pseudo-random operands. Each one is judged against a behavioural model that permutes by XOR indexing and widens through real arithmetic.

// File: rtl/bitperm_move_unit.sv
module bitperm_move_unit #(
  parameter int unsigned DW = 64
) (
  input  logic [2:0]            op_i,
  input  logic [DW-1:0]         operand_i,
  input  logic [$clog2(DW)-1:0] sh_i,
  input  logic                  rec_i,
  input  logic                  xer_so_i,
  input  logic [3:0]            fpscr_i,
  output logic [DW-1:0]         result_o,
  output logic                  dst_gpr_o,
  output logic                  cr_we_o,
  output logic [2:0]            cr_idx_o,
  output logic [3:0]            cr_val_o
);
  localparam int unsigned STAGES = $clog2(DW);

  function automatic logic [31:0] narrow_sp(input logic [63:0] d);
    logic signed [12:0] es;
    logic signed [12:0] shf;
    logic [23:0]        m;
    logic [31:0]        r;
    es  = $signed({2'b00, d[62:52]}) - 13'sd896;
    shf = 13'sd1 - es;
    m   = {1'b1, d[51:29]};
    if (d[62:52] == 11'h7ff)
      r = (d[51:0] == '0) ? {d[63], 8'hff, 23'd0} : {d[63], 8'hff, 1'b1, d[50:29]};
    else if (d[62:52] == 11'd0)
      r = {d[63], 31'd0};
    else if (es >= 13'sd255)
      r = {d[63], 8'hff, 23'd0};
    else if (es >= 13'sd1)
      r = {d[63], es[7:0], d[51:29]};
    else if (shf >= 13'sd24)
      r = {d[63], 31'd0};
    else
      r = {d[63], 8'd0, 23'(m >> shf[4:0])};
    return r;
  endfunction

  function automatic logic [63:0] widen_dp(input logic [31:0] w);
    logic [4:0]  p;
    logic [22:0] fr;
    logic [63:0] r;
    p = '0;
    for (int i = 0; i < 23; i++)
      if (w[i]) p = 5'(i);
    fr = w[22:0] << (5'd23 - p);
    if (w[30:23] == 8'hff)
      r = {w[31], 11'h7ff, w[22:0], 29'd0};
    else if (w[30:23] != 8'd0)
      r = {w[31], 11'd896 + {3'b000, w[30:23]}, w[22:0], 29'd0};
    else if (w[22:0] == 23'd0)
      r = {w[31], 63'd0};
    else
      r = {w[31], 11'd874 + {6'd0, p}, fr, 29'd0};
    return r;
  endfunction

  logic          narrow_en, widen_en;
  logic [DW-1:0] stg [0:STAGES];

  assign narrow_en = (op_i == 3'd1) || (op_i == 3'd2) || (op_i == 3'd7);
  assign widen_en  = (op_i == 3'd1) || (op_i == 3'd3) || (op_i == 3'd5);
  assign dst_gpr_o = op_i[2] & op_i[1];

  assign stg[0] = narrow_en ? {{(DW-32){1'b0}}, narrow_sp(operand_i)} : operand_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [DW-1:0] swp;
    always_comb
      for (int i = 0; i < DW; i++)
        swp[i] = stg[k][i ^ (1 << k)];
    assign stg[k+1] = sh_i[k] ? swp : stg[k];
  end

  assign result_o = widen_en ? widen_dp(stg[STAGES][31:0]) : stg[STAGES];

  assign cr_we_o  = rec_i;
  assign cr_idx_o = (rec_i && !dst_gpr_o) ? 3'd1 : 3'd0;
  assign cr_val_o = !rec_i   ? 4'd0 :
                    dst_gpr_o ? {result_o[DW-1], !result_o[DW-1] && (|result_o),
                                 ~|result_o, xer_so_i} :
                                fpscr_i;
endmodule

module bitperm_move_unit_chk (
  input logic [2:0]  op_i,
  input logic [63:0] operand_i,
  input logic [5:0]  sh_i,
  input logic        rec_i,
  input logic        xer_so_i,
  input logic [3:0]  fpscr_i,
  input logic [63:0] result_o,
  input logic        dst_gpr_o,
  input logic        cr_we_o,
  input logic [2:0]  cr_idx_o,
  input logic [3:0]  cr_val_o
);
  always_comb begin
    if (!$isunknown({op_i, operand_i, sh_i, rec_i, xer_so_i, fpscr_i})) begin
      // R1
      dst_tag_chk: assert (dst_gpr_o == (op_i == 3'd6 || op_i == 3'd7))
        else $error("dst tag mismatch");
      // R10
      cr_quiet_chk: assert (rec_i || (!cr_we_o && cr_idx_o == 3'd0 && cr_val_o == 4'd0))
        else $error("cr active without record");
      // R8
      fpr_cr_chk: assert (!(rec_i && !dst_gpr_o) || (cr_we_o && cr_idx_o == 3'd1 && cr_val_o == fpscr_i))
        else $error("fpr cr field wrong");
      // R9
      gpr_cr_chk: assert (!(rec_i && dst_gpr_o) ||
                          (cr_we_o && cr_idx_o == 3'd0 && cr_val_o[3] == result_o[63] &&
                           cr_val_o[1] == (result_o == 64'd0) && cr_val_o[0] == xer_so_i))
        else $error("gpr cr field wrong");
      // R3
      copy_chk: assert (!((op_i == 3'd0 || op_i == 3'd4 || op_i == 3'd6) && sh_i == 6'd0) ||
                        result_o == operand_i)
        else $error("plain copy altered bits");
      // R4
      narrow_hi_chk: assert (!((op_i == 3'd2 || op_i == 3'd7) && sh_i == 6'd0) ||
                             result_o[63:32] == 32'd0)
        else $error("narrowed high word not clear");
    end
  end
endmodule

bind bitperm_move_unit bitperm_move_unit_chk u_chk (
  .op_i(op_i), .operand_i(operand_i), .sh_i(sh_i), .rec_i(rec_i),
  .xer_so_i(xer_so_i), .fpscr_i(fpscr_i), .result_o(result_o),
  .dst_gpr_o(dst_gpr_o), .cr_we_o(cr_we_o), .cr_idx_o(cr_idx_o),
  .cr_val_o(cr_val_o)
);

// File: tb/bitperm_move_unit_tb.sv
module bitperm_move_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op;
  logic [63:0] opnd;
  logic [5:0]  sh;
  logic        rec, so;
  logic [3:0]  fps;
  logic [63:0] res;
  logic        dgpr, crwe;
  logic [2:0]  cridx;
  logic [3:0]  crval;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  bitperm_move_unit u_dut (
    .op_i(op), .operand_i(opnd), .sh_i(sh), .rec_i(rec), .xer_so_i(so),
    .fpscr_i(fps), .result_o(res), .dst_gpr_o(dgpr), .cr_we_o(crwe),
    .cr_idx_o(cridx), .cr_val_o(crval)
  );

  function automatic logic [63:0] m_grev(input logic [63:0] v, input logic [5:0] s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[i ^ int'(s)];
    return r;
  endfunction

  function automatic logic [31:0] m_narrow(input logic [63:0] d);
    int e, es, shift;
    logic [23:0] m;
    e = int'(d[62:52]);
    if (e == 2047) return (d[51:0] == 0) ? {d[63], 31'h7f800000} : {d[63], 9'h1ff, d[50:29]};
    if (e == 0) return {d[63], 31'd0};
    es = e - 1023 + 127;
    if (es > 254) return {d[63], 31'h7f800000};
    if (es > 0) return {d[63], 8'(es), d[51:29]};
    shift = 1 - es;
    m = {1'b1, d[51:29]};
    for (int i = 0; i < shift && i < 30; i++) m = m / 2;
    return {d[63], 8'd0, m[22:0]};
  endfunction

  function automatic logic [63:0] m_widen(input logic [31:0] w);
    real v;
    int e;
    e = int'(w[30:23]);
    if (e == 255) return {w[31], 11'h7ff, w[22:0], 29'd0};
    if (e == 0 && w[22:0] == 0) return {w[31], 63'd0};
    if (e == 0) v = real'(w[22:0]) * (2.0 ** -149);
    else v = (1.0 + real'(w[22:0]) / (2.0 ** 23)) * (2.0 ** (e - 127));
    if (w[31]) v = -v;
    return $realtobits(v);
  endfunction

  function automatic logic [63:0] m_result(input logic [2:0] o, input logic [63:0] d, input logic [5:0] s);
    logic [63:0] v;
    v = (o == 1 || o == 2 || o == 7) ? {32'd0, m_narrow(d)} : d;
    v = m_grev(v, s);
    if (o == 1 || o == 3 || o == 5) v = m_widen(v[31:0]);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [63:0] d, input logic [5:0] s,
                     input logic r, input logic x, input logic [3:0] f,
                     input string tag, input logic lit_en, input logic [63:0] lit);
    logic [63:0] er;
    logic        eg;
    logic [3:0]  ev;
    @(posedge clk); #1;
    op = o; opnd = d; sh = s; rec = r; so = x; fps = f;
    @(negedge clk);
    er = m_result(o, d, s);
    eg = (o >= 3'd6);
    if (!r) ev = 4'd0;
    else if (eg) ev = {er[63], ($signed(er) > 0), (er == 0), x};
    else ev = f;
    if (lit_en) chk({tag, " literal"}, res, lit);
    chk({tag, " model"}, res, er);
    chk("R1 dst tag", {63'd0, dgpr}, {63'd0, eg});
    chk(r ? (eg ? "R9 cr" : "R8 cr") : "R10 cr",
        {57'd0, crwe, cridx, crval}, {57'd0, r, (r && !eg) ? 3'd1 : 3'd0, ev});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    op = '0; opnd = '0; sh = '0; rec = 1'b0; so = 1'b0; fps = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle cr", {57'd0, crwe, cridx, crval}, 64'd0);
    chk("R3 idle result", res, 64'd0);
    run(0, 64'h0123456789abcdef, 0,  0, 0, 0, "R3 copy", 1, 64'h0123456789abcdef);
    run(0, 64'h0123456789abcdef, 56, 0, 0, 0, "R2 byte rev", 1, 64'hefcdab8967452301);
    run(4, 64'h0000000000000001, 63, 0, 0, 0, "R2 full rev", 1, 64'h8000000000000000);
    run(6, 64'h8000000000000005, 0,  1, 1, 4'hf, "R9 negative", 1, 64'h8000000000000005);
    run(6, 64'h0000000000000000, 0,  1, 0, 4'hf, "R9 zero", 1, 64'h0);
    run(6, 64'h0000000000000100, 8,  1, 1, 4'h0, "R9 positive", 1, 64'h0000000000000001);
    run(7, 64'h3ff0000000000000, 0,  0, 0, 0, "R4 narrow 1.0", 1, 64'h000000003f800000);
    run(7, 64'h3ff0000000000000, 32, 1, 0, 0, "R11 narrow to high word", 1, 64'h3f80000000000000);
    run(5, 64'h000000003f800000, 0,  1, 0, 4'ha, "R6 widen 1.0", 1, 64'h3ff0000000000000);
    run(5, 64'hdeadbeef3f800000, 0,  0, 0, 0, "R6 high word ignored", 1, 64'h3ff0000000000000);
    run(3, 64'h0000000000000001, 0,  0, 0, 0, "R7 denormal", 1, 64'h36a0000000000000);
    run(5, 64'h00000000ff800000, 0,  0, 0, 0, "R7 -inf", 1, 64'hfff0000000000000);
    run(5, 64'h0000000080000000, 0,  0, 0, 0, "R7 -zero", 1, 64'h8000000000000000);
    run(2, 64'h7ff0000000000001, 0,  0, 0, 0, "R5 NaN", 1, 64'h000000007fc00000);
    run(2, 64'hfff0000000000000, 0,  0, 0, 0, "R5 -inf", 1, 64'h00000000ff800000);
    run(2, 64'h7e37e43c8800759c, 0,  0, 0, 0, "R5 overflow", 1, 64'h000000007f800000);
    run(2, 64'h37d0000000000000, 0,  0, 0, 0, "R5 small denormal", 1, 64'h0000000000080000);
    run(2, 64'h0000000000000001, 0,  0, 0, 0, "R5 double denormal", 1, 64'h0);
    run(1, 64'h3ff0000000000000, 32, 0, 0, 0, "R11 empty low word", 1, 64'h0);
    run(1, 64'h3ff8000000000000, 0,  1, 0, 4'h5, "R4 R6 round trip", 1, 64'h3ff8000000000000);
    run(6, 64'h1234000000000000, 0,  0, 1, 4'hf, "R10 no record", 1, 64'h1234000000000000);
    for (int n = 0; n < 600; n++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      if (n % 3 == 0) d[62:52] = 11'd1023 + 11'(($urandom() % 300)) - 11'd150;
      run(3'($urandom()), d, 6'($urandom()), 1'($urandom()), 1'($urandom()),
          4'($urandom()), "R2 R4 R6 random", 0, 64'h0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule